// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector with Fanout

This block picks one of two free-running clocks and copies it to four identical outputs. Changing the select input never produces a shortened pulse. The side that is running first closes its gate on a falling edge of its own clock. The incoming side then waits for that closure to reach its own domain and keeps the outputs low for a fixed number of its own cycles. Only after that does it open its gate.

A force input lets the switchover finish when the outgoing clock has died. The outgoing side is cleared without waiting for its own edges, and the incoming side stops waiting for it. An output-enable input and a power-down input act on the outputs without any clock. While the outputs are disabled, a level input picks the static value they drive. A two-bit status output shows which source is currently gated through.

Top module: `clk_fanout_switch`

## Requirements
- R1: With `sel` = 0 the primary clock is the source, and with `sel` = 1 the secondary clock is. Once a source is released, all four bits of `clk_out` are equal and follow that clock: high in its high phase, low in its low phase.
- R2: After `sel` moves away from a running source, that source's gate closes on the falling edge that follows the third rising edge of its clock. The count starts at the first rising edge that samples the new `sel`.
- R3: The incoming clock is not released at once. After the outgoing gate closes, the outputs stay low across at least five and at most seven rising edges of the incoming clock: two synchroniser stages, one start cycle and three hold cycles. The outputs then follow the incoming clock.
- R4: With `force_sw` low, a switchover away from a stopped clock does not complete. Raising `force_sw` clears the outgoing side at once, and the incoming clock is released without the handshake. `force_sw` is expected low from reset.
- R5: During a switchover no high or low pulse on `clk_out` is shorter than the shorter half-period of the two input clocks.
- R6: With `oe` low, the outputs leave the clock and drive the parked level immediately, without any clock edge.
- R7: While the outputs are disabled, all four bits equal `park_lvl` (1 gives 4'hF, 0 gives 4'h0), and a change of `park_lvl` shows at once.
- R8: With `pwr_dn` high, all outputs are 0, whatever the values of `oe` and `park_lvl`.
- R9: `live_src` bit 0 marks the primary clock as released and bit 1 marks the secondary clock. At most one bit is set. A bit is set only once that clock actually reaches the outputs, never during its hold cycles.
- R10: A `sel` change that arrives while the incoming clock is still in its hold cycles does not abort it. That clock is first released (its `live_src` bit is seen set), and the new choice is served afterwards.
- R11: While `rst_n` is low, `live_src` is 0 and, with the outputs enabled, `clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary clock source |
| clk_sec | input | 1 | Secondary clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source select: 0 primary, 1 secondary |
| force_sw | input | 1 | Complete a switchover without the outgoing clock |
| oe | input | 1 | Output enable, asynchronous |
| park_lvl | input | 1 | Static output level while disabled |
| pwr_dn | input | 1 | Power-down: all outputs low |
| clk_out | output | 4 | Four copies of the selected clock |
| live_src | output | 2 | Released source (bit 0 primary, bit 1 secondary) |

## Verification
Some properties are checked on every cycle. These are the bound on how long an outgoing gate can stay open after its select drops, the rule that a domain never jumps from idle straight to released, the mutual exclusion of the two status bits, and the output levels under power-down and disable. Other behaviour can only be shown by the bench's scenarios. That includes the exact edge on which the outgoing gate closes and the count of low cycles before the incoming clock appears. It also includes the absence of runt pulses across a real switchover, completion of a switchover held during hold cycles, and the stuck-versus-forced outcome with a dead clock.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    localparam int N_SRC = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ON
    } dom_st_e;
endpackage

// File: rtl/cfs_sync.sv
module cfs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cfs_domain.sv
module cfs_domain
    import cfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic clk,
    input  logic arst_n,
    input  logic want_raw,
    input  logic peer_busy,
    input  logic skip_peer,
    output logic gate_o,
    output logic busy_o
);
    localparam int CNT_W  = $clog2(HOLD_CYC + 1);
    localparam int PARK_W = $clog2(SYNC_STAGES + 3) + 1;

    typedef struct packed {
        dom_st_e          st;
        logic [CNT_W-1:0] cnt;
    } dom_regs_t;

    dom_regs_t r_d, r_q;
    logic      want_s, peer_busy_s, peer_free;
    logic      gate_q;

    cfs_sync #(.STAGES(SYNC_STAGES)) i_want_sync (
        .clk(clk), .arst_n(arst_n), .d(want_raw), .q(want_s));
    cfs_sync #(.STAGES(SYNC_STAGES)) i_peer_sync (
        .clk(clk), .arst_n(arst_n), .d(peer_busy), .q(peer_busy_s));

    assign peer_free = skip_peer || !peer_busy_s;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: if (want_s && peer_free) begin
                r_d.st  = ST_HOLD;
                r_d.cnt = '0;
            end
            // once counting has begun it finishes, even if the select moved
            ST_HOLD: if (r_q.cnt == CNT_W'(HOLD_CYC - 1)) r_d.st = ST_ON;
                     else r_d.cnt = r_q.cnt + 1'b1;
            ST_ON:   if (!want_s) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '{st: ST_IDLE, cnt: '0};
        else         r_q <= r_d;
    end

    // gate moves only while the clock is low: no runt on either side
    always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) gate_q <= 1'b0;
        else         gate_q <= (r_q.st == ST_ON);
    end

    assign gate_o = gate_q;
    assign busy_o = (r_q.st != ST_IDLE) || gate_q;

    // checker: cycles the gate stays open after the raw select dropped
    logic [PARK_W-1:0] park_q;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                                   park_q <= '0;
        else if (!want_raw && gate_q && (&park_q == 1'b0)) park_q <= park_q + 1'b1;
        else if (want_raw || !gate_q)                  park_q <= '0;
    end

    a_r2_park_bound: assert property (@(posedge clk) disable iff (!arst_n)
        park_q <= PARK_W'(SYNC_STAGES + 1))
        else $error("R2: gate open too long after deselect");

    a_r3_no_direct_release: assert property (@(posedge clk) disable iff (!arst_n)
        (r_q.st == ST_IDLE) |=> (r_q.st != ST_ON))
        else $error("R3: released without hold");
endmodule

// File: rtl/cfs_fanout.sv
module cfs_fanout #(
    parameter int N_OUT = 4
) (
    input  logic             clk_in,
    input  logic             oe,
    input  logic             park_lvl,
    input  logic             pwr_dn,
    output logic [N_OUT-1:0] q
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_drv
        always_comb begin
            if (pwr_dn)   q[k] = 1'b0;
            else if (!oe) q[k] = park_lvl;
            else          q[k] = clk_in;
        end
    end
endmodule

// File: rtl/clk_fanout_switch.sv
module clk_fanout_switch
    import cfs_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic             clk_pri,
    input  logic             clk_sec,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             force_sw,
    input  logic             oe,
    input  logic             park_lvl,
    input  logic             pwr_dn,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_SRC-1:0] live_src
);
    logic [N_SRC-1:0] clk_vec, gate, busy;
    logic             clk_mux;

    assign clk_vec = {clk_sec, clk_pri};

    for (genvar i = 0; i < N_SRC; i++) begin : g_dom
        logic want, arst;
        assign want = (sel == 1'(i));
        // forced switch: the deselected side is cleared without its clock
        assign arst = rst_n & ~(force_sw & ~want);

        cfs_domain #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) i_dom (
            .clk       (clk_vec[i]),
            .arst_n    (arst),
            .want_raw  (want),
            .peer_busy (busy[N_SRC-1-i]),
            .skip_peer (force_sw),
            .gate_o    (gate[i]),
            .busy_o    (busy[i])
        );
    end

    assign clk_mux  = |(clk_vec & gate);
    assign live_src = gate;

    cfs_fanout #(.N_OUT(N_OUT)) i_fan (
        .clk_in(clk_mux), .oe(oe), .park_lvl(park_lvl), .pwr_dn(pwr_dn), .q(clk_out));

    a_r9_one_source: assert property (@(posedge clk_pri) disable iff (!rst_n)
        $onehot0(live_src))
        else $error("R9: both sources live");

    a_r8_power_down: assert property (@(posedge clk_pri) disable iff (!rst_n)
        pwr_dn |-> (clk_out == '0))
        else $error("R8: output active in power-down");

    a_r7_park_level: assert property (@(posedge clk_pri) disable iff (!rst_n)
        (!oe && !pwr_dn) |-> (clk_out == {N_OUT{park_lvl}}))
        else $error("R7: parked level wrong");
endmodule

// File: tb/test_clk_fanout_switch.sv
module test_clk_fanout_switch;
    logic       clk_pri = 1'b0, clk_sec = 1'b0;
    logic       rst_n, sel, force_sw, oe, park_lvl, pwr_dn;
    logic [3:0] clk_out;
    logic [1:0] live_src;
    bit         pri_run = 1'b1, sec_run = 1'b1;
    int         n_chk = 0, n_err = 0;

    clk_fanout_switch i_clk_fanout_switch (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .rst_n(rst_n), .sel(sel),
        .force_sw(force_sw), .oe(oe), .park_lvl(park_lvl), .pwr_dn(pwr_dn),
        .clk_out(clk_out), .live_src(live_src));

    // 50 MHz primary, 38.5 MHz secondary; a stopped clock rests low
    always begin #10; if (pri_run || clk_pri) clk_pri = ~clk_pri; end
    always begin #13; if (sec_run || clk_sec) clk_sec = ~clk_sec; end

    // runt monitor on one output copy
    bit  mon_en = 1'b0, t_valid = 1'b0;
    time t_edge;
    int  runt_cnt = 0;
    always @(clk_out[0]) begin
        if (mon_en && t_valid && ($time - t_edge) < 9) runt_cnt++;
        t_edge  = $time;
        t_valid = 1'b1;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic follow(input bit src, input string req);
        if (src) @(posedge clk_sec); else @(posedge clk_pri);
        #5 chk(clk_out == 4'hF, req, clk_out, 4'hF);
        if (src) @(negedge clk_sec); else @(negedge clk_pri);
        #5 chk(clk_out == 4'h0, req, clk_out, 4'h0);
    endtask

    task automatic t_reset();
        rst_n = 0; sel = 0; force_sw = 0; oe = 1; park_lvl = 0; pwr_dn = 0;
        #55;
        chk(live_src == 2'b00, "R11 status in reset", live_src, 0);
        chk(clk_out == 4'h0, "R11 outputs in reset", clk_out, 0);
        rst_n = 1;
        repeat (20) @(posedge clk_pri);
        #5 chk(live_src == 2'b01, "R9 primary live after reset", live_src, 1);
        follow(0, "R1 follow primary");
    endtask

    task automatic t_to_sec();
        int lowcnt = 0, early = 0;
        t_valid = 0; mon_en = 1; runt_cnt = 0;
        @(posedge clk_pri); #3 sel = 1;
        repeat (3) @(posedge clk_pri);
        @(negedge clk_pri); #2;
        chk(live_src[0] == 1'b0, "R2 primary parked on third edge", live_src, 0);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk_sec); #5;
            if (clk_out != 4'h0) break;
            lowcnt++;
            if (live_src[1]) early++;
        end
        chk(lowcnt >= 5 && lowcnt <= 7, "R3 low edges before release", lowcnt, 6);
        chk(early == 0, "R9 status not set during hold", early, 0);
        chk(live_src == 2'b10, "R9 secondary live", live_src, 2);
        follow(1, "R1 follow secondary");
        chk(runt_cnt == 0, "R5 no runt pri to sec", runt_cnt, 0);
    endtask

    task automatic t_reverse();
        bit saw_pri = 0;
        runt_cnt = 0;
        @(posedge clk_pri); #3 sel = 0;
        for (int i = 0; i < 40 && live_src != 2'b00; i++) @(posedge clk_pri) #5;
        repeat (3) @(posedge clk_pri);
        #3 sel = 1;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk_pri); #5; if (live_src[0]) saw_pri = 1;
            @(negedge clk_pri); #5; if (live_src[0]) saw_pri = 1;
        end
        chk(saw_pri, "R10 held switch released primary", saw_pri, 1);
        chk(live_src == 2'b10, "R10 new choice served after", live_src, 2);
        chk(runt_cnt == 0, "R5 no runt on reversal", runt_cnt, 0);
    endtask

    task automatic t_force();
        runt_cnt = 0;
        sec_run = 0;
        repeat (4) @(posedge clk_pri);
        #3 sel = 0;
        repeat (30) @(posedge clk_pri);
        #5 chk(live_src == 2'b10, "R4 stuck without force", live_src, 2);
        force_sw = 1;
        #1 chk(live_src[1] == 1'b0, "R4 dead side cleared at once", live_src, 0);
        repeat (15) @(posedge clk_pri);
        #5 chk(live_src == 2'b01, "R4 forced to primary", live_src, 1);
        follow(0, "R4 follow primary after force");
        chk(runt_cnt == 0, "R5 no runt on forced switch", runt_cnt, 0);
        force_sw = 0; sec_run = 1;
        repeat (10) @(posedge clk_pri);
    endtask

    task automatic t_disable();
        mon_en = 0;
        @(posedge clk_pri); #4;
        oe = 0; park_lvl = 0;
        #1 chk(clk_out == 4'h0, "R6 disable in high phase", clk_out, 0);
        park_lvl = 1;
        #1 chk(clk_out == 4'hF, "R7 park high", clk_out, 4'hF);
        @(negedge clk_pri); #4;
        chk(clk_out == 4'hF, "R7 park high in low phase", clk_out, 4'hF);
        park_lvl = 0;
        #1 chk(clk_out == 4'h0, "R7 park low", clk_out, 0);
        oe = 1;
        follow(0, "R6 re-enable follows");
    endtask

    task automatic t_power();
        @(posedge clk_pri); #4;
        pwr_dn = 1;
        #1 chk(clk_out == 4'h0, "R8 power-down in high phase", clk_out, 0);
        oe = 0; park_lvl = 1;
        #1 chk(clk_out == 4'h0, "R8 power-down over park", clk_out, 0);
        pwr_dn = 0;
        #1 chk(clk_out == 4'hF, "R7 park after power-up", clk_out, 4'hF);
        oe = 1; park_lvl = 0;
        follow(0, "R8 follows after power-down");
    endtask

    initial begin
        #4_000_000;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_to_sec();
        t_reverse();
        t_force();
        t_disable();
        t_power();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule